// File: doc/BRIEF.md
# Three-Channel Ring Buffer Pointer Controller

This block keeps the pointer state for three ring buffers that carry words between host memory and a card. Each channel has three 32-bit registers: pointer A, pointer B, and a wrap word. The wrap word gives the first and last word index of that channel's buffer. A single control word sets, per channel, whether DMA traffic may move the pointers and whether link activity is enabled. The same control word reports the link loss-of-signal input, shows a per-channel almost-empty flag, and holds a self-clearing card reset. That reset puts every pointer back at its buffer's first index.

A register bus with a 5-bit word index gives the host access to all of this state. Reads return their data one cycle after the request. The engines that move data raise a one-cycle produce strobe or consume strobe for each word they move on a channel. Channel 0 carries host-to-link traffic. Channels 1 and 2 carry link-to-host traffic. The channel's direction decides which pointer each strobe advances.

Top module: `ring_ptr_controller`

## Requirements
- R1: After reset, all pointers read 0, every wrap word reads 0x000F0000 (first index 0, last index 15), all enables are 0 and all three almost-empty flags are 1.
- R2: The control word is at index 16. Channel 0 uses indices 17/18/19 (A/B/wrap), channel 1 uses 20/21/22 and channel 2 uses 23/24/25. Pointer registers keep only bits [15:0] of a write and read back zero-extended. All other indices read 0, and writes to them are ignored. Read data appears on the cycle after the read request.
- R3: On channel 0, pointer A is the producer pointer, advanced by the produce strobe, and pointer B is advanced by the consume strobe. On channels 1 and 2, pointer A is advanced by the consume strobe and pointer B by the produce strobe.
- R4: A pointer that advances while it equals the wrap word's last index (bits [31:16]) takes the wrap word's first index (bits [15:0]). Otherwise it increments by one.
- R5: Produce and consume strobes of a channel have no effect while that channel's DMA enable bit (control bit ch) is 0.
- R6: Control bits [2:0] are the DMA enables and bits [5:3] the link enables for channels 0 to 2. They are writable, readable, and driven on the dmaEn and linkEn outputs.
- R7: Control bit 6 reads the current linkLos input, and writes to it have no effect.
- R8: Control bits [9:7] and the almostEmpty output give, per channel, occupancy <= 4. Occupancy is (producer - consumer) modulo (last - first + 1).
- R9: Writing the control word with bit 31 set drives cardReset high for exactly one cycle. At the clock edge that ends that cycle, every pointer takes its channel's first index. Enables and wrap words are kept, and bit 31 then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 5 | Register word index |
| regWrEn | input | 1 | Register write request |
| regWrData | input | 32 | Register write data |
| regRdEn | input | 1 | Register read request |
| regRdData | output | 32 | Read data, registered |
| produceStb | input | 3 | Per-channel word-produced strobe |
| consumeStb | input | 3 | Per-channel word-consumed strobe |
| linkLos | input | 1 | Link loss-of-signal status |
| dmaEn | output | 3 | Per-channel DMA enable |
| linkEn | output | 3 | Per-channel link enable |
| almostEmpty | output | 3 | Per-channel almost-empty flag |
| cardReset | output | 1 | One-cycle card reset pulse |

## Verification
A pointer load, a strobe or an enable write takes effect at the next clock edge. The almostEmpty flags follow the pointers within that same cycle, and cardReset rises at the edge that takes the write. Read data is due exactly one edge after the read request. The pointer rewind is due one edge after cardReset rises. The bench drives its inputs on falling edges and samples the flags there, one edge after a stimulus. Each expected read value goes into a queue, and a monitor pops it on the falling edge that follows the edge at which the read was taken.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int NUM_CH = 3;
  localparam int PTR_W  = 16;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  // strobes from control to datapath, one bit per channel
  typedef struct packed {
    logic [NUM_CH-1:0] ldA;
    logic [NUM_CH-1:0] ldB;
    logic [NUM_CH-1:0] ldWrap;
    logic [NUM_CH-1:0] advA;
    logic [NUM_CH-1:0] advB;
    logic              rewind;
    logic [DATA_W-1:0] wrData;
  } dpStrobeT;
endpackage

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_ptr_pkg::*;
#(
  parameter int CSR_IDX = 16,
  parameter int CH_BASE_IDX = 17,
  parameter logic [NUM_CH-1:0] HOST_TO_LINK = 3'b001
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic regRdEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] produceStb,
  input  logic [NUM_CH-1:0] consumeStb,
  input  logic linkLos,
  input  logic [NUM_CH-1:0][PTR_W-1:0] ptrA,
  input  logic [NUM_CH-1:0][PTR_W-1:0] ptrB,
  input  logic [NUM_CH-1:0][DATA_W-1:0] wrapW,
  input  logic [NUM_CH-1:0] aeFlags,
  output logic [NUM_CH-1:0] dmaEn,
  output logic [NUM_CH-1:0] linkEn,
  output logic cardReset,
  output dpStrobeT strobe
);
  localparam int LINK_LSB = NUM_CH;
  localparam int LOS_BIT  = 2 * NUM_CH;
  localparam int AE_LSB   = 2 * NUM_CH + 1;
  localparam int RST_BIT  = DATA_W - 1;
  localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_IDX);

  logic [NUM_CH-1:0] dmaEnQ, linkEnQ;
  logic rstPulseQ;
  logic csrWr;
  logic [DATA_W-1:0] rdMux, rdDataQ;
  logic [NUM_CH-1:0] ldA, ldB, ldWrap, advA, advB;

  assign csrWr = regWrEn && (regAddr == CSR_A);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaEnQ    <= '0;
      linkEnQ   <= '0;
      rstPulseQ <= 1'b0;
    end else begin
      rstPulseQ <= csrWr && regWrData[RST_BIT];
      if (csrWr) begin
        dmaEnQ  <= regWrData[NUM_CH-1:0];
        linkEnQ <= regWrData[LINK_LSB +: NUM_CH];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    localparam int IDX = CH_BASE_IDX + 3 * ch;
    logic prodOk, consOk;
    assign prodOk     = produceStb[ch] && dmaEnQ[ch];
    assign consOk     = consumeStb[ch] && dmaEnQ[ch];
    assign ldA[ch]    = regWrEn && (regAddr == ADDR_W'(IDX));
    assign ldB[ch]    = regWrEn && (regAddr == ADDR_W'(IDX + 1));
    assign ldWrap[ch] = regWrEn && (regAddr == ADDR_W'(IDX + 2));
    if (HOST_TO_LINK[ch]) begin : gOut
      assign advA[ch] = prodOk;
      assign advB[ch] = consOk;
    end else begin : gIn
      assign advA[ch] = consOk;
      assign advB[ch] = prodOk;
    end
  end

  assign strobe = '{ldA: ldA, ldB: ldB, ldWrap: ldWrap, advA: advA,
                    advB: advB, rewind: rstPulseQ, wrData: regWrData};

  always_comb begin
    rdMux = '0;
    if (regAddr == CSR_A) begin
      rdMux[NUM_CH-1:0]          = dmaEnQ;
      rdMux[LINK_LSB +: NUM_CH]  = linkEnQ;
      rdMux[LOS_BIT]             = linkLos;
      rdMux[AE_LSB +: NUM_CH]    = aeFlags;
      rdMux[RST_BIT]             = rstPulseQ;
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (regAddr == ADDR_W'(CH_BASE_IDX + 3 * ch))     rdMux = DATA_W'(ptrA[ch]);
      if (regAddr == ADDR_W'(CH_BASE_IDX + 3 * ch + 1)) rdMux = DATA_W'(ptrB[ch]);
      if (regAddr == ADDR_W'(CH_BASE_IDX + 3 * ch + 2)) rdMux = wrapW[ch];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdDataQ <= '0;
    else if (regRdEn) rdDataQ <= rdMux;
  end

  assign regRdData = rdDataQ;
  assign dmaEn     = dmaEnQ;
  assign linkEn    = linkEnQ;
  assign cardReset = rstPulseQ;
endmodule

// File: rtl/ring_ptr_dp.sv
module ring_ptr_dp
  import ring_ptr_pkg::*;
#(
  parameter logic [DATA_W-1:0] DEF_WRAP = 32'h000F_0000,
  parameter int AE_LEVEL = 4,
  parameter logic [NUM_CH-1:0] HOST_TO_LINK = 3'b001
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobeT strobe,
  output logic [NUM_CH-1:0][PTR_W-1:0] ptrA,
  output logic [NUM_CH-1:0][PTR_W-1:0] ptrB,
  output logic [NUM_CH-1:0][DATA_W-1:0] wrapW,
  output logic [NUM_CH-1:0] aeFlags
);
  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p,
                                               input logic [PTR_W-1:0] first,
                                               input logic [PTR_W-1:0] last);
    return (p == last) ? first : p + 1'b1;
  endfunction

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    logic [PTR_W-1:0] aQ, bQ, first, last, prod, cons;
    logic [DATA_W-1:0] wQ;
    logic [PTR_W:0] size, occ;

    assign first = wQ[PTR_W-1:0];
    assign last  = wQ[2*PTR_W-1:PTR_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aQ <= DEF_WRAP[PTR_W-1:0];
        bQ <= DEF_WRAP[PTR_W-1:0];
        wQ <= DEF_WRAP;
      end else if (strobe.rewind) begin
        aQ <= first;
        bQ <= first;
      end else begin
        if (strobe.ldA[ch])       aQ <= strobe.wrData[PTR_W-1:0];
        else if (strobe.advA[ch]) aQ <= stepPtr(aQ, first, last);
        if (strobe.ldB[ch])       bQ <= strobe.wrData[PTR_W-1:0];
        else if (strobe.advB[ch]) bQ <= stepPtr(bQ, first, last);
        if (strobe.ldWrap[ch])    wQ <= strobe.wrData;
      end
    end

    if (HOST_TO_LINK[ch]) begin : gOut
      assign prod = aQ;
      assign cons = bQ;
    end else begin : gIn
      assign prod = bQ;
      assign cons = aQ;
    end

    always_comb begin
      size = {1'b0, last} - {1'b0, first} + 1'b1;
      if (prod >= cons) occ = {1'b0, prod} - {1'b0, cons};
      else              occ = {1'b0, prod} + size - {1'b0, cons};
    end

    assign aeFlags[ch] = (occ <= (PTR_W + 1)'(AE_LEVEL));
    assign ptrA[ch]    = aQ;
    assign ptrB[ch]    = bQ;
    assign wrapW[ch]   = wQ;
  end
endmodule

// File: rtl/ring_ptr_controller.sv
module ring_ptr_controller
  import ring_ptr_pkg::*;
#(
  parameter int CSR_IDX = 16,
  parameter int CH_BASE_IDX = 17,
  parameter logic [NUM_CH-1:0] HOST_TO_LINK = 3'b001,
  parameter logic [DATA_W-1:0] DEF_WRAP = 32'h000F_0000,
  parameter int AE_LEVEL = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic regRdEn,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] produceStb,
  input  logic [NUM_CH-1:0] consumeStb,
  input  logic linkLos,
  output logic [NUM_CH-1:0] dmaEn,
  output logic [NUM_CH-1:0] linkEn,
  output logic [NUM_CH-1:0] almostEmpty,
  output logic cardReset
);
  dpStrobeT strobe;
  logic [NUM_CH-1:0][PTR_W-1:0] ptrA, ptrB;
  logic [NUM_CH-1:0][DATA_W-1:0] wrapW;
  logic [NUM_CH-1:0] aeFlags;

  ring_ptr_ctrl #(.CSR_IDX(CSR_IDX), .CH_BASE_IDX(CH_BASE_IDX),
                  .HOST_TO_LINK(HOST_TO_LINK)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .produceStb(produceStb), .consumeStb(consumeStb), .linkLos(linkLos),
    .ptrA(ptrA), .ptrB(ptrB), .wrapW(wrapW), .aeFlags(aeFlags),
    .dmaEn(dmaEn), .linkEn(linkEn), .cardReset(cardReset), .strobe(strobe)
  );

  ring_ptr_dp #(.DEF_WRAP(DEF_WRAP), .AE_LEVEL(AE_LEVEL),
                .HOST_TO_LINK(HOST_TO_LINK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ptrA(ptrA), .ptrB(ptrB), .wrapW(wrapW), .aeFlags(aeFlags)
  );

  assign almostEmpty = aeFlags;
endmodule

// File: rtl/ring_ptr_checker.sv
module ring_ptr_checker
  import ring_ptr_pkg::*;
#(
  parameter int CSR_IDX = 16,
  parameter logic [NUM_CH-1:0] HOST_TO_LINK = 3'b001
) (
  input logic clk,
  input logic rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic regWrEn,
  input logic regRdEn,
  input logic [DATA_W-1:0] regRdData,
  input logic linkLos,
  input logic [NUM_CH-1:0] produceStb,
  input logic [NUM_CH-1:0] consumeStb,
  input logic [NUM_CH-1:0] dmaEn,
  input logic cardReset,
  input logic [NUM_CH-1:0][PTR_W-1:0] ptrA,
  input logic [NUM_CH-1:0][PTR_W-1:0] ptrB,
  input logic [NUM_CH-1:0][DATA_W-1:0] wrapW
);
  logic [NUM_CH-1:0] advAReq;
  assign advAReq = (HOST_TO_LINK & produceStb) | (~HOST_TO_LINK & consumeStb);

  // R9: the reset pulse lasts one cycle
  assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    cardReset |=> !cardReset);

  // R7: loss-of-signal bit reflects the input at the read request
  assert_los_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(CSR_IDX)) |=> regRdData[2*NUM_CH] == $past(linkLos));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChk
    // R9: pointers rewind to first index after the pulse
    assert_rewind_R9: assert property (@(posedge clk) disable iff (!rstN)
      cardReset |=> (ptrA[ch] == $past(wrapW[ch][PTR_W-1:0]))
                 && (ptrB[ch] == $past(wrapW[ch][PTR_W-1:0])));
    // R5: strobes ignored while DMA disabled
    assert_dma_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
      (!dmaEn[ch] && !regWrEn && !cardReset) |=> $stable(ptrA[ch]) && $stable(ptrB[ch]));
    // R4: pointer A wraps from last index to first index
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
      (dmaEn[ch] && advAReq[ch] && !regWrEn && !cardReset
       && ptrA[ch] == wrapW[ch][2*PTR_W-1:PTR_W])
      |=> ptrA[ch] == $past(wrapW[ch][PTR_W-1:0]));
  end
endmodule

bind ring_ptr_controller ring_ptr_checker #(.CSR_IDX(CSR_IDX), .HOST_TO_LINK(HOST_TO_LINK)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regRdData(regRdData), .linkLos(linkLos), .produceStb(produceStb),
  .consumeStb(consumeStb), .dmaEn(dmaEn), .cardReset(cardReset),
  .ptrA(ptrA), .ptrB(ptrB), .wrapW(wrapW)
);

// File: tb/ring_ptr_controller_tb.sv
`timescale 1ns/1ps
module ring_ptr_controller_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [2:0] produceStb = '0;
  logic [2:0] consumeStb = '0;
  logic linkLos = 1'b0;
  logic [2:0] dmaEn, linkEn, almostEmpty;
  logic cardReset;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic rdIssued = 1'b0;
  logic [31:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  ring_ptr_controller u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .produceStb(produceStb), .consumeStb(consumeStb), .linkLos(linkLos),
    .dmaEn(dmaEn), .linkEn(linkEn), .almostEmpty(almostEmpty),
    .cardReset(cardReset)
  );

  task automatic checkEq(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    regAddr = a; regRdEn = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic stb(logic [2:0] p, logic [2:0] c, int n);
    for (int i = 0; i < n; i++) begin
      produceStb = p; consumeStb = c;
      @(negedge clk);
    end
    produceStb = '0; consumeStb = '0;
  endtask

  // monitor: read data due one edge after the request
  always @(posedge clk) rdIssued <= regRdEn;
  always @(negedge clk) begin
    if (rdIssued) begin
      if (expQ.size() == 0) begin
        checkEq("scoreboard-underflow R2", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        checkEq(t, regRdData, e);
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all requirements got=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 dmaEn", 32'(dmaEn), 32'h0);
    checkEq("R1 almostEmpty", 32'(almostEmpty), 32'h7);
    checkEq("R1 cardReset", 32'(cardReset), 32'h0);
    rd(16, 32'h380, "R1 control word");
    rd(17, 32'h0, "R1 ptr A ch0");
    rd(24, 32'h0, "R1 ptr B ch2");
    rd(19, 32'h000F0000, "R1 wrap ch0");
    // R2 unused indices
    wr(5, 32'hFFFF_FFFF);
    rd(5, 32'h0, "R2 unused index 5");
    rd(30, 32'h0, "R2 unused index 30");
    wr(17, 32'hABCD_0009);
    rd(17, 32'h9, "R2 pointer width");
    wr(17, 32'h0);
    // R6 enables
    wr(16, 32'h3F);
    checkEq("R6 dmaEn", 32'(dmaEn), 32'h7);
    checkEq("R6 linkEn", 32'(linkEn), 32'h7);
    // R7 loss of signal
    linkLos = 1'b1;
    rd(16, 32'h3FF, "R7 los set");
    linkLos = 1'b0;
    wr(16, 32'h7F);
    rd(16, 32'h3BF, "R7 los write ignored");
    // R3 channel 0 producer on A
    stb(3'b001, 3'b000, 5);
    checkEq("R8 ch0 occupancy 5", 32'(almostEmpty), 32'h6);
    rd(17, 32'd5, "R3 ch0 A by produce");
    rd(18, 32'd0, "R3 ch0 B idle");
    stb(3'b000, 3'b001, 1);
    checkEq("R8 ch0 occupancy 4", 32'(almostEmpty), 32'h7);
    rd(18, 32'd1, "R3 ch0 B by consume");
    // R3 channel 1 producer on B
    stb(3'b010, 3'b000, 3);
    rd(21, 32'd3, "R3 ch1 B by produce");
    rd(20, 32'd0, "R3 ch1 A idle");
    // R8 occupancy across wrap: 3 - 14 + 16 = 5
    wr(20, 32'd14);
    checkEq("R8 ch1 wrapped occupancy", 32'(almostEmpty), 32'h5);
    rd(16, 32'h2BF, "R8 control flags");
    // R5 gating
    wr(16, 32'h3E);
    stb(3'b001, 3'b001, 2);
    rd(17, 32'd5, "R5 ch0 A frozen");
    rd(18, 32'd1, "R5 ch0 B frozen");
    wr(16, 32'h3F);
    // R4 wrap on channel 2: first 4, last 7
    wr(25, 32'h0007_0004);
    wr(23, 32'd6);
    wr(24, 32'd7);
    stb(3'b100, 3'b000, 1);
    rd(24, 32'd4, "R4 ch2 B wraps");
    stb(3'b000, 3'b100, 2);
    rd(23, 32'd4, "R4 ch2 A wraps");
    // R9 card reset
    wr(16, 32'h8000_003F);
    checkEq("R9 pulse high", 32'(cardReset), 32'h1);
    @(negedge clk);
    checkEq("R9 pulse low", 32'(cardReset), 32'h0);
    checkEq("R9 flags after rewind", 32'(almostEmpty), 32'h7);
    rd(17, 32'd0, "R9 ch0 A rewound");
    rd(18, 32'd0, "R9 ch0 B rewound");
    rd(20, 32'd0, "R9 ch1 A rewound");
    rd(23, 32'd4, "R9 ch2 A to first");
    rd(24, 32'd4, "R9 ch2 B to first");
    rd(25, 32'h0007_0004, "R9 wrap kept");
    rd(16, 32'h3BF, "R9 bit31 clear enables kept");
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule